// File: doc/BRIEF.md
# Stuck Bus Timeout and Recovery

This block watches the clock and data lines of the downstream segment of a two-wire bus and decides when that segment has hung. A timeout counter runs for as long as the two lines are not both high. A single cycle in which both are high restarts it. When the counter reaches its limit, the block raises a fault flag and a disconnect request. The connection controller beside it uses that request to split the upstream and downstream segments.

After a guard delay the block releases a burst of clock pulses on the downstream clock line through a pull-low request. Each pulse is low for a half period and released for a half period. At the end of each released half it looks at the bus. If both lines are high, it stops pulsing and drives a STOP condition: it pulls data low while clock is released, holds for a half period, then lets data go. The fault then clears.

If the whole burst goes by without a release, the block stays faulted and re-arms the timeout for a new attempt. A low enable inhibits all generated activity and freezes the recovery sequence. A rising edge on enable while a fault is pending clears the fault at once and sends a one-cycle force-connect request. All times are parameters in clock cycles.

Top module: `stuck_bus_recovery`

## Requirements
- R1: `fault_o` rises on the clock edge that samples the TIMEOUT_CYC-th consecutive cycle in which `scl_i` and `sda_i` are not both high, and not earlier; detection runs whatever the level of `en_i`.
- R2: Any sampled cycle with `scl_i` and `sda_i` both high, while no fault is pending, restarts the timeout count from zero.
- R3: `disconnect_o` equals `fault_o` at all times, and neither pull-low output is ever asserted without a pending fault.
- R4: After the fault rises, `scl_pull_o` stays low for GUARD_CYC cycles; the first pulse begins in the cycle after that.
- R5: Each generated pulse asserts `scl_pull_o` for exactly HALF_CYC cycles and then releases it for HALF_CYC cycles.
- R6: One attempt issues at most MAX_PULSES pulses. If the bus has not released by the end of the last released half, pulsing stops, `fault_o` stays high and a new attempt starts after another full timeout.
- R7: If both lines are high at the end of a released half, pulsing ends. `sda_pull_o` is then asserted for HALF_CYC cycles while `scl_pull_o` stays low, and `fault_o` clears in the cycle `sda_pull_o` drops.
- R8: While `en_i` is low, neither `scl_pull_o` nor `sda_pull_o` is asserted, and the recovery sequence does not advance.
- R9: A rising edge on `en_i` while `fault_o` is high makes `force_conn_o` high for exactly one cycle, starting on the next edge, and clears `fault_o` on that same edge.
- R10: During and right after reset, all outputs are low.
- R11: With a fault still pending after an exhausted attempt, a sampled cycle with both lines high clears `fault_o` on the next edge without any STOP sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enable for connection and recovery |
| scl_i | input | 1 | Sampled level of the downstream clock line |
| sda_i | input | 1 | Sampled level of the downstream data line |
| scl_pull_o | output | 1 | Request to pull the downstream clock line low |
| sda_pull_o | output | 1 | Request to pull the downstream data line low |
| fault_o | output | 1 | Stuck-bus fault pending |
| disconnect_o | output | 1 | Request to split the upstream and downstream segments |
| force_conn_o | output | 1 | One-cycle request to connect the segments at once |

## Verification
The assertions assume that `scl_i` and `sda_i` are already synchronised, hold stable across each sampling edge, and read high only when neither the block nor any other device pulls them. The bench meets this by building each line as a wired-AND of a bench-driven level and the inverse of the block's own pull-low output. It changes that level and `en_i` only at falling clock edges. The run-length and STOP checks rely on `en_i` staying high through a pulse or STOP phase, and the stimulus drops `en_i` only when no pulse is in flight.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  typedef enum logic [2:0] {
    ST_WATCH  = 3'd0,
    ST_GUARD  = 3'd1,
    ST_CLK_LO = 3'd2,
    ST_CLK_HI = 3'd3,
    ST_STOP   = 3'd4
  } rec_state_t;

  function automatic logic lines_high(input logic scl, input logic sda);
    return scl & sda;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // cycles from fault declaration to the first pulse edge, seen from the port
  function automatic int unsigned first_pulse_delay(input int unsigned guard);
    return guard;
  endfunction

  // cycles one full attempt occupies after its first pulse starts
  function automatic int unsigned burst_cycles(input int unsigned half, input int unsigned pulses);
    return 2 * half * pulses;
  endfunction

endpackage

// File: rtl/sbr_timeout_mon.sv
module sbr_timeout_mon #(
  parameter int unsigned TIMEOUT_CYC = 4_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic bus_high_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = arm_i & ~bus_high_i & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 cnt_q <= '0;
    else if (!arm_i || bus_high_i || expire_o)  cnt_q <= '0;
    else                                        cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/sbr_phase_timer.sv
module sbr_phase_timer #(
  parameter int unsigned MAX_LEN = 9_091,
  localparam int unsigned LW = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [LW-1:0] len_i,
  input  logic          tick_i,
  output logic          done_o
);
  logic [LW-1:0] cnt_q;

  assign done_o = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (start_i)              cnt_q <= len_i - LW'(1);
    else if (tick_i && !done_o)    cnt_q <= cnt_q - LW'(1);
  end
endmodule

// File: rtl/sbr_recovery_fsm.sv
module sbr_recovery_fsm
  import sbr_pkg::*;
#(
  parameter int unsigned GUARD_CYC  = 4_000,
  parameter int unsigned HALF_CYC   = 9_091,
  parameter int unsigned MAX_PULSES = 16,
  parameter int unsigned LW         = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          bus_high_i,
  input  logic          expire_i,
  input  logic          phase_done_i,
  output logic          arm_o,
  output logic          phase_start_o,
  output logic [LW-1:0] phase_len_o,
  output logic          phase_tick_o,
  output logic          scl_pull_o,
  output logic          sda_pull_o,
  output logic          fault_o,
  output logic          force_conn_o,
  output logic          pulse_end_o,
  output logic          release_o
);
  localparam int unsigned PW = $clog2(MAX_PULSES + 1);
  localparam logic [PW-1:0] LAST_PULSE = PW'(MAX_PULSES - 1);

  rec_state_t    state_q, state_d;
  logic          fault_q, fault_d;
  logic          force_q;
  logic          force_d;
  logic          en_q;
  logic [PW-1:0] pulse_cnt_q;
  logic          timed, step, en_rise;

  assign en_rise      = en_i & ~en_q;
  assign timed        = (state_q != ST_WATCH);
  assign phase_tick_o = en_i & timed;
  assign step         = phase_tick_o & phase_done_i;
  assign pulse_end_o  = step & (state_q == ST_CLK_HI);
  assign release_o    = pulse_end_o & bus_high_i;
  assign arm_o        = (state_q == ST_WATCH);

  always_comb begin
    state_d       = state_q;
    fault_d       = fault_q;
    force_d       = 1'b0;
    phase_start_o = 1'b0;
    phase_len_o   = LW'(HALF_CYC);
    if (fault_q && en_rise) begin
      state_d = ST_WATCH;
      fault_d = 1'b0;
      force_d = 1'b1;
    end else begin
      unique case (state_q)
        ST_WATCH: begin
          if (expire_i) begin
            state_d       = ST_GUARD;
            fault_d       = 1'b1;
            phase_start_o = 1'b1;
            phase_len_o   = LW'(GUARD_CYC);
          end else if (bus_high_i) begin
            fault_d = 1'b0;
          end
        end
        ST_GUARD: if (step) begin
          state_d       = ST_CLK_LO;
          phase_start_o = 1'b1;
        end
        ST_CLK_LO: if (step) begin
          state_d       = ST_CLK_HI;
          phase_start_o = 1'b1;
        end
        ST_CLK_HI: if (step) begin
          if (release_o) begin
            state_d       = ST_STOP;
            phase_start_o = 1'b1;
          end else if (pulse_cnt_q == LAST_PULSE) begin
            state_d = ST_WATCH;
          end else begin
            state_d       = ST_CLK_LO;
            phase_start_o = 1'b1;
          end
        end
        ST_STOP: if (step) begin
          state_d = ST_WATCH;
          fault_d = 1'b0;
        end
        default: state_d = ST_WATCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_WATCH;
      fault_q     <= 1'b0;
      force_q     <= 1'b0;
      en_q        <= 1'b0;
      pulse_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
      force_q <= force_d;
      en_q    <= en_i;
      if (state_q == ST_GUARD)  pulse_cnt_q <= '0;
      else if (pulse_end_o)     pulse_cnt_q <= pulse_cnt_q + PW'(1);
    end
  end

  assign scl_pull_o   = en_i & (state_q == ST_CLK_LO);
  assign sda_pull_o   = en_i & (state_q == ST_STOP);
  assign fault_o      = fault_q;
  assign force_conn_o = force_q;
endmodule

// File: rtl/stuck_bus_recovery.sv
module stuck_bus_recovery
  import sbr_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 4_500_000,
  parameter int unsigned GUARD_CYC   = 4_000,
  parameter int unsigned HALF_CYC    = 9_091,
  parameter int unsigned MAX_PULSES  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_pull_o,
  output logic sda_pull_o,
  output logic fault_o,
  output logic disconnect_o,
  output logic force_conn_o
);
  localparam int unsigned MAX_LEN = max_u(GUARD_CYC, HALF_CYC);
  localparam int unsigned LW      = $clog2(MAX_LEN + 1);

  // named internal events, visible to the bound checker
  logic          bus_high_w;
  logic          expire_w;
  logic          arm_w;
  logic          phase_start_w;
  logic [LW-1:0] phase_len_w;
  logic          phase_tick_w;
  logic          phase_done_w;
  logic          pulse_end_w;
  logic          release_w;

  assign bus_high_w = lines_high(scl_i, sda_i);

  sbr_timeout_mon #(.TIMEOUT_CYC(TIMEOUT_CYC)) tmo_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (arm_w),
    .bus_high_i (bus_high_w),
    .expire_o   (expire_w)
  );

  sbr_phase_timer #(.MAX_LEN(MAX_LEN)) phase_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (phase_start_w),
    .len_i   (phase_len_w),
    .tick_i  (phase_tick_w),
    .done_o  (phase_done_w)
  );

  sbr_recovery_fsm #(
    .GUARD_CYC (GUARD_CYC),
    .HALF_CYC  (HALF_CYC),
    .MAX_PULSES(MAX_PULSES),
    .LW        (LW)
  ) fsm_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_i),
    .bus_high_i   (bus_high_w),
    .expire_i     (expire_w),
    .phase_done_i (phase_done_w),
    .arm_o        (arm_w),
    .phase_start_o(phase_start_w),
    .phase_len_o  (phase_len_w),
    .phase_tick_o (phase_tick_w),
    .scl_pull_o   (scl_pull_o),
    .sda_pull_o   (sda_pull_o),
    .fault_o      (fault_o),
    .force_conn_o (force_conn_o),
    .pulse_end_o  (pulse_end_w),
    .release_o    (release_w)
  );

  assign disconnect_o = fault_o;
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
  parameter int unsigned HALF_CYC = 9_091
) (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic scl_i,
  input logic sda_i,
  input logic scl_pull_o,
  input logic sda_pull_o,
  input logic fault_o,
  input logic disconnect_o,
  input logic force_conn_o,
  input logic expire_w,
  input logic release_w
);
  logic [31:0] lo_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lo_run_q <= '0;
    else if (scl_pull_o) lo_run_q <= lo_run_q + 32'd1;
    else                 lo_run_q <= '0;
  end

  assert_fault_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> $past(!(scl_i && sda_i)));

  assert_expire_sets_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
    expire_w |=> fault_o);

  assert_pull_needs_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull_o || sda_pull_o) |-> (fault_o && disconnect_o));

  assert_low_half_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull_o |-> (lo_run_q < 32'(HALF_CYC)));

  assert_pulls_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_pull_o && sda_pull_o));

  assert_release_starts_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    release_w |=> (sda_pull_o || !en_i));

  assert_stop_end_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_pull_o) && en_i && $past(en_i)) |-> !fault_o);

  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (!scl_pull_o && !sda_pull_o));

  assert_force_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_conn_o |-> ($past(fault_o) && !fault_o && en_i));

  assert_force_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_conn_o |=> !force_conn_o);
endmodule

bind stuck_bus_recovery sbr_checker #(.HALF_CYC(HALF_CYC)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_i        (en_i),
  .scl_i       (scl_i),
  .sda_i       (sda_i),
  .scl_pull_o  (scl_pull_o),
  .sda_pull_o  (sda_pull_o),
  .fault_o     (fault_o),
  .disconnect_o(disconnect_o),
  .force_conn_o(force_conn_o),
  .expire_w    (expire_w),
  .release_w   (release_w)
);

// File: tb/stuck_bus_recovery_tb.sv
`timescale 1ns/1ps
module stuck_bus_recovery_tb_top;
  localparam int unsigned T_CYC = 40;
  localparam int unsigned G_CYC = 8;
  localparam int unsigned H_CYC = 5;
  localparam int unsigned NPULS = 16;
  localparam int unsigned WDOG  = 20_000;

  // row: [19] scl level, [18] sda level, [17] enable, [16] expected fault, [15:0] cycles held
  localparam int NROW = 8;
  localparam logic [19:0] VEC [NROW] = '{
    {1'b1, 1'b1, 1'b1, 1'b0, 16'd5},
    {1'b1, 1'b0, 1'b1, 1'b0, 16'(T_CYC - 1)},
    {1'b1, 1'b1, 1'b1, 1'b0, 16'd1},
    {1'b1, 1'b0, 1'b1, 1'b0, 16'(T_CYC - 1)},
    {1'b1, 1'b1, 1'b1, 1'b0, 16'd1},
    {1'b0, 1'b1, 1'b1, 1'b0, 16'd20},
    {1'b0, 1'b0, 1'b1, 1'b0, 16'(T_CYC - 21)},
    {1'b1, 1'b0, 1'b1, 1'b1, 16'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic scl_lvl = 1'b1;
  logic sda_lvl = 1'b1;
  logic scl_pull, sda_pull, fault, disc, force_conn;
  logic scl_bus, sda_bus;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  assign scl_bus = scl_lvl & ~scl_pull;
  assign sda_bus = sda_lvl & ~sda_pull;

  stuck_bus_recovery #(
    .TIMEOUT_CYC(T_CYC),
    .GUARD_CYC  (G_CYC),
    .HALF_CYC   (H_CYC),
    .MAX_PULSES (NPULS)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en),
    .scl_i       (scl_bus),
    .sda_i       (sda_bus),
    .scl_pull_o  (scl_pull),
    .sda_pull_o  (sda_pull),
    .fault_o     (fault),
    .disconnect_o(disc),
    .force_conn_o(force_conn)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // observe n cycles: new clock pulses, low runs of wrong length, cycles without fault, STOP pulls
  task automatic observe(input int n, output int rises, output int bad_lo,
                         output int no_fault, output int sda_hits);
    logic prev;
    int   run;
    prev = scl_pull; run = scl_pull ? 1 : 0;
    rises = 0; bad_lo = 0; no_fault = 0; sda_hits = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (scl_pull) begin
        if (!prev) begin rises++; run = 1; end
        else run++;
      end else if (prev && run != int'(H_CYC)) begin
        bad_lo++;
      end
      if (!fault) no_fault++;
      if (sda_pull) sda_hits++;
      prev = scl_pull;
    end
  endtask

  initial begin
    int r, b, nf, sh;
    // R10: reset state
    @(negedge clk);
    chk("R10 scl_pull in reset", scl_pull, 0);
    chk("R10 fault in reset", fault, 0);
    chk("R10 force in reset", force_conn, 0);
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    chk("R10 outputs after reset", {scl_pull, sda_pull, fault, disc, force_conn}, 0);

    // R1 R2: timeout counting, restart on both-high
    for (int k = 0; k < NROW; k++) begin
      scl_lvl = VEC[k][19];
      sda_lvl = VEC[k][18];
      en      = VEC[k][17];
      cyc(int'(VEC[k][15:0]));
      chk($sformatf("R1/R2 row %0d fault", k), fault, int'(VEC[k][16]));
    end
    chk("R3 disconnect follows fault", disc, 1);

    // R4: guard delay before the first pulse
    cyc(int'(sbr_pkg::first_pulse_delay(G_CYC)) - 1);
    chk("R4 no pulse during guard", scl_pull, 0);
    cyc(1);
    chk("R4 first pulse after guard", scl_pull, 1);

    // R5 R6: full burst, exhaust, new attempt after a fresh timeout
    observe(int'(sbr_pkg::burst_cycles(H_CYC, NPULS)) + int'(T_CYC) + int'(G_CYC) - 1, r, b, nf, sh);
    chk("R6 remaining pulses in attempt", r, int'(NPULS) - 1);
    chk("R5 low half length", b, 0);
    chk("R6 fault kept through exhaust", nf, 0);
    chk("R7 no stop without release", sh, 0);
    cyc(1);
    chk("R6 next attempt begins", scl_pull, 1);

    // R7: release during a pulse, STOP then clear
    sda_lvl = 1'b1;
    cyc(2 * int'(H_CYC) - 1);
    chk("R7 no stop before half end", sda_pull, 0);
    chk("R7 fault held before stop", fault, 1);
    cyc(1);
    chk("R7 stop pulls data", sda_pull, 1);
    chk("R7 clock released in stop", scl_pull, 0);
    cyc(int'(H_CYC) - 1);
    chk("R7 stop held half period", sda_pull, 1);
    cyc(1);
    chk("R7 stop released", sda_pull, 0);
    chk("R7 fault cleared after stop", fault, 0);
    observe(30, r, b, nf, sh);
    chk("R7 pulsing ended", r, 0);

    // R8: enable low, no pulls, sequence frozen
    en = 1'b0;
    scl_lvl = 1'b0;
    cyc(int'(T_CYC));
    chk("R1/R8 fault detected while disabled", fault, 1);
    observe(100, r, b, nf, sh);
    chk("R8 no clock pulls while disabled", r, 0);
    chk("R8 no data pulls while disabled", sh, 0);
    chk("R8 fault held while disabled", nf, 0);

    // R9: enable rising edge forces connection
    en = 1'b1;
    cyc(1);
    chk("R9 force pulse", force_conn, 1);
    chk("R9 fault cleared", fault, 0);
    chk("R3 disconnect cleared", disc, 0);
    scl_lvl = 1'b1;
    cyc(1);
    chk("R9 force single cycle", force_conn, 0);

    // R11: exhausted attempt then bus frees on its own
    sda_lvl = 1'b0;
    cyc(int'(T_CYC) + int'(G_CYC) + int'(sbr_pkg::burst_cycles(H_CYC, NPULS)));
    chk("R11 fault after exhaust", fault, 1);
    chk("R11 no pull after exhaust", scl_pull, 0);
    sda_lvl = 1'b1;
    cyc(1);
    chk("R11 fault cleared by idle bus", fault, 0);
    chk("R11 no stop sequence", sda_pull, 0);

    // R10: reset during a fault
    scl_lvl = 1'b0;
    cyc(int'(T_CYC));
    chk("R10 fault before mid reset", fault, 1);
    rst_n = 1'b0;
    #1;
    chk("R10 fault cleared by reset", fault, 0);
    scl_lvl = 1'b1;
    cyc(1);
    rst_n = 1'b1;
    cyc(1);
    chk("R10 quiet after mid reset", {scl_pull, sda_pull, fault, force_conn}, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule